// File: doc/BRIEF.md
# Watchdog Timer with Cross-Domain Clear

This watchdog serves a small microcontroller. Its counter is clocked by a selectable counter clock: the internal RC oscillator clock or the CPU clock. The CPU writes its control register in the CPU clock domain. Counting starts when the run bit is set. A two-bit mode field picks the interrupt interval. When the counter reaches that interval, an interrupt flag is set in the CPU domain. If software does not restart the counter, a fixed number of counter clocks later a one-cycle system reset pulse is issued, provided reset is enabled.

The reset-enable, interrupt-flag and restart bits are guarded. A write to them takes effect only inside a short unlock window, which a two-write key sequence on a separate key register opens. A restart request crosses to the counter domain as a toggle. The restart bit reads back as set until the CPU domain has seen the counter at zero and then counting again. If the counter clock has stopped, the bit stays set, so software polls it before entering a low-power state.

Top module: `wdt_top`

## Requirements
- R1: After reset the control register reads 0x00: run off, mode 00 (the shortest interval), flag, reset-enable and restart bits clear. `irq_o` and `sys_rst_o` are low.
- R2: The mode field is control bits 5:4 and holds a value m. With counting enabled, the interrupt point is 2^(BASE_LOG2 + STEP_LOG2*m) counter clocks after the counter starts from zero. The defaults give 2^17, 2^20, 2^23 and 2^26.
- R3: RST_DELAY counter clocks after the interrupt point (default 512), `sys_rst_o` pulses high for exactly one CPU cycle, provided reset-enable (bit 1) is 1 and no restart occurred. With reset-enable at 0, no pulse occurs.
- R4: Writing 0xAA and then, on the next CPU cycle, 0x55 to the key register (address 1) opens an unlock window covering the following 3 CPU cycles. Inside the window, one control write (address 0) may change bits 3, 1 and 0. A write outside the window, or after a broken key sequence, leaves those bits unchanged.
- R5: The run bit (bit 7) and the mode field accept any control write without unlocking. Counting happens only while run is 1.
- R6: A guarded write with bit 0 at 1 restarts the counter from zero and makes bit 0 read 1. Bit 0 returns to 0 only after the CPU domain has seen the counter at zero and then non-zero. While the counter clock is stopped, or run is 0, bit 0 stays 1.
- R7: At the interrupt point the flag (bit 3) is set and `irq_o` goes high. Only a guarded write with bit 3 at 0 clears it. An unguarded write does not clear it.
- R8: With `clk_sel_i` at 1 the counter counts CPU clocks. With `clk_sel_i` at 0 it counts `rc_clk_i` cycles.
- R9: Restarts spaced closer together than the interrupt interval keep `irq_o` low and `sys_rst_o` quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rc_clk_i | input | 1 | Internal RC oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| clk_sel_i | input | 1 | Counter clock select: 1 CPU clock, 0 RC clock |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 control register, 1 key register |
| wr_data_i | input | 8 | Write data |
| ctrl_o | output | 8 | Control register read value {run,0,mode[1:0],flag,0,rst_en,restart} |
| irq_o | output | 1 | Watchdog interrupt flag |
| sys_rst_o | output | 1 | One-cycle system reset pulse |

## Verification
The assertions assume three things about the inputs:
- The mode field and the clock select are held steady while events are pending.
- At most one register write occurs per cycle.
- The counter clock is not faster than the CPU clock, so the one-cycle zero on the counter's non-zero status is always seen by the CPU domain.

The stimulus follows these assumptions:
- It changes mode only through a restart write, with the counter at its end value.
- It switches the clock select only once both events of the previous interval have fired.
- It runs the RC clock at a quarter of the CPU rate.
- It stops the RC clock only to show a restart bit that stays set.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned CTRL_W = 8;
  localparam int unsigned BIT_RUN = 7;
  localparam int unsigned BIT_MODE_LO = 4;
  localparam int unsigned BIT_FLAG = 3;
  localparam int unsigned BIT_RSTEN = 1;
  localparam int unsigned BIT_CLR = 0;
  localparam int unsigned NUM_MODES = 4;
  localparam logic [CTRL_W-1:0] KEY_FIRST = 8'hAA;
  localparam logic [CTRL_W-1:0] KEY_SECOND = 8'h55;

  typedef enum logic {
    ADDR_CTRL = 1'b0,
    ADDR_KEY  = 1'b1
  } wdt_addr_e;
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/wdt_unlock.sv
module wdt_unlock
  import wdt_pkg::*;
#(
  parameter int unsigned WIN_CYCLES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_wr_i,
  input  logic [CTRL_W-1:0] key_data_i,
  input  logic              ctrl_wr_i,
  output logic              open_o
);
  localparam int unsigned WIN_W = $clog2(WIN_CYCLES + 1);

  logic             first_q;
  logic [WIN_W-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b0;
      win_q   <= '0;
    end else begin
      first_q <= key_wr_i && (key_data_i == KEY_FIRST);
      if (key_wr_i && (key_data_i == KEY_SECOND) && first_q) begin
        win_q <= WIN_W'(WIN_CYCLES);
      end else if (ctrl_wr_i) begin
        win_q <= '0;  // one guarded write per unlock
      end else if (win_q != '0) begin
        win_q <= win_q - 1'b1;
      end
    end
  end

  assign open_o = (win_q != '0);

  AST_OPEN_NEEDS_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(key_wr_i && (key_data_i == KEY_SECOND))); // R4
  AST_WIN_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && ctrl_wr_i) |=> !open_o); // R4
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 17,
  parameter int unsigned STEP_LOG2 = 3,
  parameter int unsigned RST_DELAY = 512
) (
  input  logic       cnt_clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] mode_i,
  input  logic       clr_tgl_i,
  output logic       irq_tgl_o,
  output logic       rst_tgl_o,
  output logic       nz_o
);
  localparam int unsigned CNT_W = BASE_LOG2 + STEP_LOG2 * (NUM_MODES - 1) + 2;

  logic [CNT_W-1:0] lim [NUM_MODES];
  logic [CNT_W-1:0] tmo, end_cnt, cnt_q, cnt_nxt;
  logic [1:0]       sync_out;
  logic             run_s, clr_s, clr_prev_q, clr_pulse;
  logic             irq_tgl_q, rst_tgl_q, nz_q;

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_lim
    assign lim[m] = CNT_W'(1) << (BASE_LOG2 + STEP_LOG2 * m);
  end

  wdt_sync #(.WIDTH(2)) u_sync (
    .clk_i (cnt_clk_i),
    .rst_ni(rst_ni),
    .d_i   ({run_i, clr_tgl_i}),
    .q_o   (sync_out)
  );
  assign {run_s, clr_s} = sync_out;
  assign clr_pulse = clr_s ^ clr_prev_q;

  assign tmo     = lim[mode_i];
  assign end_cnt = tmo + CNT_W'(RST_DELAY);

  always_comb begin
    cnt_nxt = cnt_q;
    if (clr_pulse) cnt_nxt = '0;
    else if (run_s && (cnt_q < end_cnt)) cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge cnt_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_prev_q <= 1'b0;
      cnt_q      <= '0;
      irq_tgl_q  <= 1'b0;
      rst_tgl_q  <= 1'b0;
      nz_q       <= 1'b0;
    end else begin
      clr_prev_q <= clr_s;
      cnt_q      <= cnt_nxt;
      nz_q       <= (cnt_nxt != '0);
      if ((cnt_nxt == tmo) && (cnt_nxt != cnt_q)) irq_tgl_q <= ~irq_tgl_q;
      if ((cnt_nxt == end_cnt) && (cnt_nxt != cnt_q)) rst_tgl_q <= ~rst_tgl_q;
    end
  end

  assign irq_tgl_o = irq_tgl_q;
  assign rst_tgl_o = rst_tgl_q;
  assign nz_o      = nz_q;

  AST_CLR_ZEROES: assert property (@(posedge cnt_clk_i) disable iff (!rst_ni)
    clr_pulse |=> (cnt_q == '0)); // R6
  AST_EVT_APART: assert property (@(posedge cnt_clk_i) disable iff (!rst_ni)
    !(!$stable(irq_tgl_q) && !$stable(rst_tgl_q))); // R3
  AST_NO_COUNT_STOPPED: assert property (@(posedge cnt_clk_i) disable iff (!rst_ni)
    (!run_s && !clr_pulse) |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int unsigned BASE_LOG2  = 17,
  parameter int unsigned STEP_LOG2  = 3,
  parameter int unsigned RST_DELAY  = 512,
  parameter int unsigned WIN_CYCLES = 3
) (
  input  logic              clk_i,
  input  logic              rc_clk_i,
  input  logic              rst_ni,
  input  logic              clk_sel_i,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              irq_o,
  output logic              sys_rst_o
);
  logic       ctrl_wr, key_wr, open;
  logic       cnt_clk;
  logic       run_q, rst_en_q, flag_q, clr_q, clr_tgl_q, seen_zero_q, sys_rst_q;
  logic [1:0] mode_q;
  logic       irq_tgl, rst_tgl, nz;
  logic [2:0] back_s;
  logic       irq_s, rst_s, nz_s, irq_prev_q, rst_prev_q, irq_evt, rst_evt;
  logic       clr_start;

  assign ctrl_wr = wr_en_i && (wdt_addr_e'(wr_addr_i) == ADDR_CTRL);
  assign key_wr  = wr_en_i && (wdt_addr_e'(wr_addr_i) == ADDR_KEY);

  wdt_unlock #(.WIN_CYCLES(WIN_CYCLES)) u_unlock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .key_wr_i  (key_wr),
    .key_data_i(wr_data_i),
    .ctrl_wr_i (ctrl_wr),
    .open_o    (open)
  );

  assign cnt_clk = clk_sel_i ? clk_i : rc_clk_i;

  wdt_counter #(
    .BASE_LOG2(BASE_LOG2),
    .STEP_LOG2(STEP_LOG2),
    .RST_DELAY(RST_DELAY)
  ) u_counter (
    .cnt_clk_i(cnt_clk),
    .rst_ni   (rst_ni),
    .run_i    (run_q),
    .mode_i   (mode_q),
    .clr_tgl_i(clr_tgl_q),
    .irq_tgl_o(irq_tgl),
    .rst_tgl_o(rst_tgl),
    .nz_o     (nz)
  );

  wdt_sync #(.WIDTH(3)) u_back (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({irq_tgl, rst_tgl, nz}),
    .q_o   (back_s)
  );
  assign {irq_s, rst_s, nz_s} = back_s;
  assign irq_evt = irq_s ^ irq_prev_q;
  assign rst_evt = rst_s ^ rst_prev_q;
  assign clr_start = ctrl_wr && open && wr_data_i[BIT_CLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      mode_q      <= 2'b00;
      rst_en_q    <= 1'b0;
      flag_q      <= 1'b0;
      clr_q       <= 1'b0;
      clr_tgl_q   <= 1'b0;
      seen_zero_q <= 1'b0;
      irq_prev_q  <= 1'b0;
      rst_prev_q  <= 1'b0;
      sys_rst_q   <= 1'b0;
    end else begin
      irq_prev_q <= irq_s;
      rst_prev_q <= rst_s;
      sys_rst_q  <= rst_evt && rst_en_q;
      if (ctrl_wr) begin
        run_q  <= wr_data_i[BIT_RUN];
        mode_q <= wr_data_i[BIT_MODE_LO+:2];
        if (open) begin
          rst_en_q <= wr_data_i[BIT_RSTEN];
          flag_q   <= wr_data_i[BIT_FLAG];
        end
      end
      if (irq_evt) flag_q <= 1'b1;
      if (clr_start) begin
        clr_q       <= 1'b1;
        clr_tgl_q   <= ~clr_tgl_q;
        seen_zero_q <= 1'b0;
      end else if (clr_q) begin
        // zero must be seen first, so a stale non-zero cannot end the request
        if (!nz_s) seen_zero_q <= 1'b1;
        if (seen_zero_q && nz_s) clr_q <= 1'b0;
      end
    end
  end

  assign ctrl_o    = {run_q, 1'b0, mode_q, flag_q, 1'b0, rst_en_q, clr_q};
  assign irq_o     = flag_q;
  assign sys_rst_o = sys_rst_q;

  AST_RST_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> !sys_rst_o); // R3
  AST_RST_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> $past(rst_en_q)); // R3
  AST_GUARD_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !open) |=> (rst_en_q == $past(rst_en_q))); // R4
  AST_CLR_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_q && !nz_s) |=> clr_q); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !(ctrl_wr && open)) |=> flag_q); // R7
endmodule

// File: tb/tb_wdt_top.sv
`timescale 1ns/1ps
module tb_wdt_top;
  localparam int unsigned BASE = 6;
  localparam int unsigned STEP = 1;
  localparam int unsigned DLY  = 16;
  localparam int T0 = 1 << BASE;
  localparam int T1 = 1 << (BASE + STEP);

  logic clk = 1'b0, rc_clk = 1'b0, rst_n = 1'b0, clk_sel = 1'b1;
  logic wr_en = 1'b0, wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] ctrl;
  logic irq, sys_rst;
  logic rc_run = 1'b1;
  int cyc = 0, checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit    is_rst;
    int    lo;
    int    hi;
    string req;
  } exp_t;
  exp_t exp_q[$];

  wdt_top #(.BASE_LOG2(BASE), .STEP_LOG2(STEP), .RST_DELAY(DLY), .WIN_CYCLES(3)) dut (
    .clk_i(clk), .rc_clk_i(rc_clk), .rst_ni(rst_n), .clk_sel_i(clk_sel),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .ctrl_o(ctrl), .irq_o(irq), .sys_rst_o(sys_rst)
  );

  always #2 clk = ~clk;
  initial forever begin
    #8;
    if (rc_run) rc_clk = ~rc_clk;
  end
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // driver helpers, entered at a falling edge
  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic guarded_wr(input logic [7:0] d);
    wr(1'b1, 8'hAA);
    wr(1'b1, 8'h55);
    wr(1'b0, d);
  endtask
  task automatic expect_evt(input bit is_rst, input int lo, input int hi, input string req);
    exp_t e;
    e.is_rst = is_rst; e.lo = cyc + lo; e.hi = cyc + hi; e.req = req;
    exp_q.push_back(e);
  endtask

  // monitor: pops expected events as irq rises and reset pulses appear
  logic irq_prev = 1'b0, rst_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if ((irq && !irq_prev) || sys_rst) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R9 unexpected %s at %0d actual=1 expected=0",
                   sys_rst ? "reset" : "irq", cyc);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (e.is_rst != sys_rst || cyc < e.lo || cyc > e.hi) begin
            errors++;
            $display("FAIL %s event rst=%0d at %0d expected rst=%0d in %0d..%0d",
                     e.req, sys_rst, cyc, e.is_rst, e.lo, e.hi);
          end
        end
      end
      if (sys_rst && rst_prev) begin
        checks++; errors++;
        $display("FAIL R3 reset pulse longer than one cycle actual=2 expected=1");
      end
    end
    irq_prev <= irq;
    rst_prev <= sys_rst;
  end

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    chk("R1 ctrl", ctrl, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 sys_rst", sys_rst, 0);

    wr(1'b0, 8'h02);
    idle(1);
    chk("R4 unguarded rst_en ignored", ctrl, 8'h00);
    guarded_wr(8'h02);
    chk("R4 guarded rst_en", ctrl, 8'h02);

    wr(1'b1, 8'hAA); wr(1'b1, 8'h55); idle(4); wr(1'b0, 8'h00);
    chk("R4 expired window", ctrl, 8'h02);
    wr(1'b1, 8'hAA); idle(1); wr(1'b1, 8'h55); wr(1'b0, 8'h00);
    chk("R4 broken key sequence", ctrl, 8'h02);

    // mode 0 with CPU clock
    wr(1'b0, 8'h82);
    chk("R5 run unguarded", ctrl, 8'h82);
    expect_evt(1'b0, T0, T0 + 10, "R2 mode0 irq");
    expect_evt(1'b1, T0 + DLY, T0 + DLY + 10, "R3 mode0 reset");
    idle(T0 + DLY + 30);
    chk("R7 flag set", ctrl, 8'h8A);
    chk("R7 irq_o", irq, 1);

    wr(1'b0, 8'h82);
    idle(1);
    chk("R7 unguarded clear ignored", ctrl, 8'h8A);
    guarded_wr(8'h82);
    idle(1);
    chk("R7 guarded clear", irq, 0);

    // mode 1 via restart
    guarded_wr(8'h93);
    chk("R6 restart bit reads set", ctrl, 8'h93);
    expect_evt(1'b0, T1, T1 + 12, "R2 mode1 irq");
    expect_evt(1'b1, T1 + DLY, T1 + DLY + 12, "R3 mode1 reset");
    idle(20);
    chk("R6 restart bit self-clears", ctrl, 8'h92);
    idle(T1 + DLY + 20);

    // reset disabled
    guarded_wr(8'h81);
    expect_evt(1'b0, T0, T0 + 12, "R3 irq with reset off");
    idle(T0 + DLY + 40);
    chk("R3 no reset when disabled flag", ctrl, 8'h88);

    // periodic restarts
    for (int i = 0; i < 6; i++) begin
      guarded_wr(8'h81);
      idle(37);
    end
    chk("R9 irq stays low", irq, 0);

    // stopped count keeps restart bit set
    wr(1'b0, 8'h00);
    guarded_wr(8'h01);
    idle(40);
    chk("R6 restart held while run off", ctrl, 8'h01);
    wr(1'b0, 8'h80);
    expect_evt(1'b0, T0, T0 + 12, "R5 irq after run");
    idle(15);
    chk("R6 restart clears once counting", ctrl, 8'h80);
    idle(T0 + DLY + 30);

    // RC counter clock
    clk_sel = 1'b0;
    idle(4);
    guarded_wr(8'h83);
    expect_evt(1'b0, 4 * T0, 4 * T0 + 40, "R8 rc irq");
    expect_evt(1'b1, 4 * (T0 + DLY), 4 * (T0 + DLY) + 40, "R8 rc reset");
    idle(4 * (T0 + DLY) + 60);
    chk("R8 restart done on rc", ctrl, 8'h8A);

    // RC clock stalled
    rc_run = 1'b0;
    guarded_wr(8'h81);
    idle(60);
    chk("R6 restart held with clock stopped", ctrl, 8'h81);
    rc_run = 1'b1;
    expect_evt(1'b0, 4 * T0, 4 * T0 + 45, "R8 irq after rc resumes");
    idle(60);
    chk("R6 restart clears after clock resumes", ctrl, 8'h80);
    idle(4 * (T0 + DLY) + 60);

    chk("R2 all expected events seen", exp_q.size(), 0);
    finish_run();
  end
endmodule